// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous requester and an asynchronous 256K x 16 dynamic RAM with multiplexed addressing. Each accepted request carries an 18-bit word address, a write flag, two byte enables and write data. The block splits the address into a 9-bit row (upper bits) and a 9-bit column (lower bits) and presents them in turn on one shared 9-bit address bus. It then generates the row strobe, one column strobe per byte lane, the write enable and the output enable, and it steers the data bus through separate out, drive-enable and in vectors.

After an access the row stays open. A following request to the same row is served with a column cycle only. A request to another row, a row that has been open too long, or a refresh request closes the row and precharges it first. All delays are counted in clock cycles and set by parameters, so the integrator converts nanosecond limits for the chosen clock. Writes always use the early-write order: the write enable falls and the data is driven a cycle before any column strobe falls, so the memory never drives the data pins during a write.

Top module: `fpm_dram_seq`

## Requirements
- R1: After synchronous reset all strobes, the write enable and the output enable are high (inactive), the data bus is not driven, `rsp_valid` and `refresh_grant` are low, and `req_ready` is high.
- R2: The row is `req_addr[17:9]` and the column is `req_addr[8:0]`. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when a column strobe falls.
- R3: A column strobe falls no sooner than `T_RCD` cycles after the row strobe falls. Each column-strobe low pulse lasts exactly `T_CAS` cycles. Within an open row, column strobes stay high at least `T_CP` cycles between pulses.
- R4: `req_be[0]` selects the lower strobe (data bits 7:0) and `req_be[1]` selects the upper strobe (bits 15:8). A strobe falls only when its enable is set. With both enables clear, neither strobe falls and memory is unchanged.
- R5: On a write, the write enable is low and the data bus is driven at least one cycle before the column strobe falls, and both stay so while the strobe is low. The output enable stays high during writes.
- R6: On a read, the output enable is low while the column strobe is low. The data is sampled in the last strobe-low cycle. `rsp_valid` pulses for one cycle in the first cycle after the strobes rise, and `rsp_rdata` holds the read word with disabled lanes returned as zero. Writes also get a `rsp_valid` pulse.
- R7: A request to the currently open row is served without raising the row strobe.
- R8: A request to another row raises the row strobe, keeps it high at least `T_RP` cycles, and then opens the new row. The row strobe is never low for fewer than `T_RAS_MIN` cycles.
- R9: The row strobe is never low for more than `T_RAS_MAX` consecutive cycles. An open row with no traffic, or a long run of same-row hits, is closed on its own.
- R10: While `refresh_req` is high, no request is accepted and the open row is closed at the next access boundary. `refresh_grant` is high only while the row is closed and precharged and all strobes are high.
- R11: `req_ready` is low from acceptance until the access has completed, so at most one access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: row in 17:9, column in 8:0 |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| refresh_req | input | 1 | Close the row and hand the bus over |
| refresh_grant | output | 1 | Row closed and strobes idle |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 16 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Data from memory |

## Verification
Word writes and reads to a fresh row test the address split and the basic read path. Repeated accesses to one row must produce no extra row-strobe falls, which separates page hits from reopens. Single-lane and empty byte-enable writes, followed by reads with partial enables, separate the two strobes from each other and test the zeroing of disabled lanes. A long run of same-row writes, an idle open row, and a refresh request raised while a row is open each force a close for a different reason, while a cycle-level memory model tracks strobe spacing, early-write order and bus contention throughout.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int ADDR_W = 18;
    localparam int ROW_W  = 9;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        S_IDLE,   // row closed and precharged
        S_ROW,    // row strobe low, waiting row-to-column delay
        S_CSET,   // column address and write setup, strobes high
        S_COL,    // column strobe(s) low
        S_DATA,   // column precharge, row still open
        S_OPEN,   // row open, waiting for next request
        S_PRE     // row strobe high, precharge
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: ROW_W];
    endfunction

    function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

    function automatic logic row_active(input seq_state_e s);
        return (s == S_ROW) || (s == S_CSET) || (s == S_COL) ||
               (s == S_DATA) || (s == S_OPEN);
    endfunction

endpackage

// File: rtl/fpm_delay.sv
module fpm_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track
    import fpm_pkg::*;
#(
    parameter int T_RAS_MIN = 13,
    parameter int T_RAS_MAX = 25000,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_low,
    input  logic             open_load,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] open_row,
    output logic             expired,
    output logic             min_met
);
    localparam int RUN_W = $clog2(T_RAS_MAX + 1);
    // last cycle in which a hit may still start without overrunning the limit
    localparam int LIMIT = T_RAS_MAX - T_CAS - T_CP - 2;
    localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(LIMIT);
    localparam logic [RUN_W-1:0] MIN_V   = RUN_W'(T_RAS_MIN);
    localparam logic [RUN_W-1:0] MINM1_V = RUN_W'(T_RAS_MIN - 1);
    localparam logic [RUN_W-1:0] MAX_V   = RUN_W'(T_RAS_MAX);

    logic [RUN_W-1:0] run_q;     // consecutive low cycles before this one
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            row_q <= '0;
        end else begin
            run_q <= ras_low ? run_q + 1'b1 : '0;
            if (open_load)
                row_q <= row_in;
        end
    end

    assign open_row = row_q;
    assign expired  = (run_q >= LIMIT_V);
    assign min_met  = (run_q >= MINM1_V);

    a_r9_open_max: assert property (@(posedge clk) disable iff (rst)
        ras_low |-> (run_q < MAX_V));

    a_r8_open_min: assert property (@(posedge clk) disable iff (rst)
        (!ras_low && run_q != '0) |-> (run_q >= MIN_V));

endmodule

// File: rtl/fpm_lane_io.sv
module fpm_lane_io
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drive,
    input  logic              capture,
    input  logic              is_write,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] rdata_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign masked[i*LANE_W +: LANE_W] =
            (be[i] && !is_write) ? dq_i[i*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= masked;
    end

    assign dq_o  = drive ? wdata : '0;
    assign dq_oe = drive;
    assign rdata = rdata_q;

endmodule

// File: rtl/fpm_dram_seq.sv
module fpm_dram_seq
    import fpm_pkg::*;
#(
    parameter int T_RCD     = 5,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 2,
    parameter int T_RP      = 8,
    parameter int T_RAS_MIN = 13,
    parameter int T_RAS_MAX = 25000,
    parameter int TIMER_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              refresh_req,
    output logic              refresh_grant,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_lcas_n,
    output logic              dram_ucas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DATA_W-1:0] dram_dq_o,
    output logic              dram_dq_oe,
    input  logic [DATA_W-1:0] dram_dq_i
);
    localparam logic [TIMER_W-1:0] L_RCD = TIMER_W'(T_RCD - 1);
    localparam logic [TIMER_W-1:0] L_CAS = TIMER_W'(T_CAS - 1);
    localparam logic [TIMER_W-1:0] L_CP  = TIMER_W'(T_CP - 1);
    localparam logic [TIMER_W-1:0] L_RP  = TIMER_W'(T_RP - 1);

    seq_state_e state_q, state_d;
    acc_req_t   cur_q;
    logic       rsp_q;

    logic             t_done, t_load;
    logic [TIMER_W-1:0] t_val;
    logic [ROW_W-1:0] open_row;
    logic             expired, min_met, hit, req_fire;
    logic [LANES-1:0] cas_n;
    logic             cas_all_n, col_end;

    // ---------------- request acceptance ----------------
    assign hit       = (row_of(req_addr) == open_row);
    assign req_ready = !refresh_req &&
                       ((state_q == S_IDLE) ||
                        (state_q == S_OPEN && hit && !expired));
    assign req_fire  = req_valid && req_ready;
    assign col_end   = (state_q == S_COL) && t_done;

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (req_fire) begin
            cur_q.write <= req_write;
            cur_q.row   <= row_of(req_addr);
            cur_q.col   <= col_of(req_addr);
            cur_q.be    <= req_be;
            cur_q.wdata <= req_wdata;
        end
    end

    // ---------------- sequencing ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_fire) state_d = S_ROW;
            S_ROW:  if (t_done) state_d = S_CSET;
            S_CSET: state_d = S_COL;
            S_COL:  if (t_done) state_d = S_DATA;
            S_DATA: if (t_done) state_d = S_OPEN;
            S_OPEN: begin
                if ((refresh_req || expired || (req_valid && !hit)) && min_met)
                    state_d = S_PRE;
                else if (req_fire)
                    state_d = S_CSET;
            end
            S_PRE:  if (t_done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            S_ROW:   t_val = L_RCD;
            S_COL:   t_val = L_CAS;
            S_DATA:  t_val = L_CP;
            S_PRE:   t_val = L_RP;
            default: t_val = '0;
        endcase
    end

    assign t_load = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            rsp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            rsp_q   <= col_end;
        end
    end

    fpm_delay #(.W(TIMER_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    fpm_page_track #(
        .T_RAS_MIN (T_RAS_MIN),
        .T_RAS_MAX (T_RAS_MAX),
        .T_CAS     (T_CAS),
        .T_CP      (T_CP)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .ras_low   (row_active(state_q)),
        .open_load ((state_q == S_IDLE) && req_fire),
        .row_in    (row_of(req_addr)),
        .open_row  (open_row),
        .expired   (expired),
        .min_met   (min_met)
    );

    fpm_lane_io u_lanes (
        .clk      (clk),
        .rst      (rst),
        .drive    (cur_q.write && (state_q == S_CSET || state_q == S_COL)),
        .capture  (col_end),
        .is_write (cur_q.write),
        .be       (cur_q.be),
        .wdata    (cur_q.wdata),
        .dq_i     (dram_dq_i),
        .dq_o     (dram_dq_o),
        .dq_oe    (dram_dq_oe),
        .rdata    (rsp_rdata)
    );

    // ---------------- memory-side pins ----------------
    for (genvar i = 0; i < LANES; i++) begin : g_cas
        assign cas_n[i] = !((state_q == S_COL) && cur_q.be[i]);
    end

    assign cas_all_n     = &cas_n;
    assign dram_lcas_n   = cas_n[0];
    assign dram_ucas_n   = cas_n[LANES-1];
    assign dram_ras_n    = !row_active(state_q);
    assign dram_addr     = (state_q == S_ROW) ? cur_q.row : cur_q.col;
    assign dram_we_n     = !(cur_q.write && (state_q == S_CSET || state_q == S_COL));
    assign dram_oe_n     = !(!cur_q.write && state_q == S_COL);
    assign rsp_valid     = rsp_q;
    assign refresh_grant = (state_q == S_IDLE) && refresh_req;

    // ---------------- assertions ----------------
    a_r4_cas_needs_ras: assert property (@(posedge clk) disable iff (rst)
        !cas_all_n |-> !dram_ras_n);

    a_r5_we_before_cas: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_all_n) && !dram_we_n) |-> $past(!dram_we_n));

    a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> dram_dq_oe);

    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !dram_oe_n |-> !dram_dq_oe);

    a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r10_grant_quiet: assert property (@(posedge clk) disable iff (rst)
        refresh_grant |-> (dram_ras_n && cas_all_n && dram_we_n));

    a_r11_one_access: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> cas_all_n);

endmodule

// File: tb/tb_fpm_dram_seq.sv
module tb_fpm_dram_seq;
    localparam int T_RCD = 3, T_CAS = 2, T_CP = 2, T_RP = 3;
    localparam int T_RAS_MIN = 10, T_RAS_MAX = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, refresh_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, refresh_grant;
    logic [15:0] rsp_rdata;
    logic [8:0]  dram_addr;
    logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_o;
    logic [15:0] dram_dq_i = 16'hA5A5;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    fpm_dram_seq #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
        .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .TIMER_W(8)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .refresh_req(refresh_req), .refresh_grant(refresh_grant),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_lcas_n(dram_lcas_n), .dram_ucas_n(dram_ucas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );

    // ---------------- memory model and protocol monitor ----------------
    logic [15:0] mem [int];
    logic [8:0]  mrow = '0, mcol = '0;
    bit p_ras = 1, p_cas_low = 0, p_we = 1, cas_seen = 0;
    int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0, max_lo = 0, min_lo = 1000000;
    int cas_lo_run = 0, cas_hi_run = 0;
    int ras_falls = 0, lfalls = 0, ufalls = 0, wr_strobes = 0, prot_err = 0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit cas_low = !dram_lcas_n || !dram_ucas_n;
            automatic int key;
            automatic logic [15:0] w;
            if (p_ras && !dram_ras_n) begin
                ras_falls++;
                mrow = dram_addr;
                last_hi = hi_run;
                if (ras_falls > 1 && hi_run < T_RP) prot_err++;
                cas_seen = 0;
            end
            if (!p_ras && dram_ras_n) begin
                last_lo = lo_run;
                if (lo_run > max_lo) max_lo = lo_run;
                if (lo_run < min_lo) min_lo = lo_run;
            end
            if (!p_cas_low && cas_low) begin
                mcol = dram_addr;
                if (dram_ras_n) prot_err++;
                if (lo_run < T_RCD) prot_err++;
                if (cas_seen && cas_hi_run < T_CP) prot_err++;
                if (!dram_lcas_n) lfalls++;
                if (!dram_ucas_n) ufalls++;
                if (!dram_we_n) begin
                    if (p_we || !dram_dq_oe || !dram_oe_n) prot_err++;
                    wr_strobes++;
                    key = int'({mrow, mcol});
                    w = mem.exists(key) ? mem[key] : 16'h0000;
                    if (!dram_lcas_n) w[7:0] = dram_dq_o[7:0];
                    if (!dram_ucas_n) w[15:8] = dram_dq_o[15:8];
                    mem[key] = w;
                end
            end
            if (p_cas_low && !cas_low) begin
                if (cas_lo_run != T_CAS) prot_err++;
                if (!rsp_valid) prot_err++;
                cas_seen = 1;
            end
            if (!dram_oe_n && dram_dq_oe) prot_err++;
            // read data
            key = int'({mrow, mcol});
            w = mem.exists(key) ? mem[key] : 16'h0000;
            dram_dq_i = 16'hA5A5;
            if (cas_low && !dram_oe_n) begin
                if (!dram_lcas_n) dram_dq_i[7:0] = w[7:0];
                if (!dram_ucas_n) dram_dq_i[15:8] = w[15:8];
            end
            if (!dram_ras_n) begin lo_run++; hi_run = 0; end
            else begin hi_run++; lo_run = 0; end
            if (cas_low) begin cas_lo_run++; cas_hi_run = 0; end
            else begin cas_hi_run++; cas_lo_run = 0; end
            p_ras = dram_ras_n;
            p_cas_low = cas_low;
            p_we = dram_we_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [8:0] row, input logic [8:0] col,
                          input logic [1:0] be, input logic [15:0] wd,
                          output logic [15:0] rd, output bit busy_ok);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = {row, col};
        req_be = be; req_wdata = wd;
        n = 0;
        while (!req_ready && n < 300) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 1'b0;
        busy_ok = 1;
        n = 0;
        while (!rsp_valid && n < 300) begin
            if (req_ready) busy_ok = 0;
            @(negedge clk); n++;
        end
        rd = rsp_rdata;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R1 strobes idle",
            {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);
        chk(dram_we_n && dram_oe_n, "R1 we/oe idle", {dram_we_n, dram_oe_n}, 2'b11);
        chk(!dram_dq_oe, "R1 bus undriven", dram_dq_oe, 0);
        chk(req_ready && !rsp_valid && !refresh_grant, "R1 host side",
            {req_ready, rsp_valid, refresh_grant}, 3'b100);
    endtask

    task automatic t_word();
        logic [15:0] rd; bit busy;
        access(1, 9'd5, 9'd10, 2'b11, 16'h1234, rd, busy);
        chk(mrow == 9'd5 && mcol == 9'd10, "R2 row/col split", {mrow, mcol}, {9'd5, 9'd10});
        chk(busy, "R11 ready low while busy (write)", busy, 1);
        access(0, 9'd5, 9'd10, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'h1234, "R6 word read back", rd, 16'h1234);
        chk(busy, "R11 ready low while busy (read)", busy, 1);
    endtask

    task automatic t_hit();
        logic [15:0] rd; bit busy; int rf0;
        rf0 = ras_falls;
        access(1, 9'd5, 9'd11, 2'b11, 16'hBEEF, rd, busy);
        access(0, 9'd5, 9'd11, 2'b11, 16'h0, rd, busy);
        chk(ras_falls == rf0, "R7 page hit keeps row open", ras_falls - rf0, 0);
        chk(rd == 16'hBEEF, "R7 page hit data", rd, 16'hBEEF);
    endtask

    task automatic t_byte();
        logic [15:0] rd; bit busy; int lf0, uf0;
        access(1, 9'd5, 9'd12, 2'b11, 16'hAAAA, rd, busy);
        lf0 = lfalls; uf0 = ufalls;
        access(1, 9'd5, 9'd12, 2'b01, 16'h0011, rd, busy);
        chk(lfalls == lf0 + 1 && ufalls == uf0, "R4 lower lane strobe only",
            {lfalls - lf0, ufalls - uf0}, {32'd1, 32'd0});
        access(0, 9'd5, 9'd12, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'hAA11, "R4 lower byte written", rd, 16'hAA11);
        access(0, 9'd5, 9'd12, 2'b10, 16'h0, rd, busy);
        chk(rd == 16'hAA00, "R6 disabled lane reads zero", rd, 16'hAA00);
        lf0 = lfalls; uf0 = ufalls;
        access(1, 9'd5, 9'd12, 2'b00, 16'hFFFF, rd, busy);
        chk(lfalls == lf0 && ufalls == uf0, "R4 no enables, no strobe",
            {lfalls - lf0, ufalls - uf0}, 0);
        access(0, 9'd5, 9'd12, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'hAA11, "R4 no enables, memory unchanged", rd, 16'hAA11);
    endtask

    task automatic t_miss();
        logic [15:0] rd; bit busy; int rf0;
        rf0 = ras_falls;
        access(1, 9'd9, 9'd3, 2'b11, 16'h0F0F, rd, busy);
        chk(ras_falls == rf0 + 1, "R8 miss reopens row", ras_falls - rf0, 1);
        chk(last_hi >= T_RP, "R8 precharge length", last_hi, T_RP);
        access(0, 9'd5, 9'd10, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'h1234 && ras_falls == rf0 + 2, "R8 back to first row", rd, 16'h1234);
        access(0, 9'd9, 9'd3, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'h0F0F, "R2 second row data", rd, 16'h0F0F);
    endtask

    task automatic t_stream();
        logic [15:0] rd; bit busy; int rf0; bit all_ok;
        rf0 = ras_falls;
        for (int i = 0; i < 10; i++)
            access(1, 9'd7, 9'(i), 2'b11, 16'(16'h7000 + i), rd, busy);
        chk(ras_falls >= rf0 + 2, "R9 long hit run forces close", ras_falls - rf0, 2);
        all_ok = 1;
        for (int i = 0; i < 10; i++) begin
            access(0, 9'd7, 9'(i), 2'b11, 16'h0, rd, busy);
            if (rd != 16'(16'h7000 + i)) all_ok = 0;
        end
        chk(all_ok, "R9 data across forced closes", all_ok, 1);
        chk(max_lo <= T_RAS_MAX, "R9 row-open maximum", max_lo, T_RAS_MAX);
        chk(min_lo >= T_RAS_MIN, "R8 row-open minimum", min_lo, T_RAS_MIN);
    endtask

    task automatic t_idle_close();
        logic [15:0] rd; bit busy;
        access(0, 9'd7, 9'd1, 2'b11, 16'h0, rd, busy);
        repeat (T_RAS_MAX + 20) @(negedge clk);
        chk(dram_ras_n, "R9 idle row closes by itself", dram_ras_n, 1);
        chk(last_lo <= T_RAS_MAX, "R9 idle open time", last_lo, T_RAS_MAX);
    endtask

    task automatic t_refresh();
        logic [15:0] rd; bit busy, seen, blocked; int n;
        access(0, 9'd5, 9'd11, 2'b11, 16'h0, rd, busy);
        @(negedge clk);
        refresh_req = 1'b1;
        seen = 0; n = 0;
        while (!seen && n < 60) begin
            @(negedge clk); n++;
            if (refresh_grant) seen = 1;
        end
        chk(seen, "R10 grant after close", seen, 1);
        chk(dram_ras_n && dram_lcas_n && dram_ucas_n, "R10 strobes idle at grant",
            {dram_ras_n, dram_lcas_n, dram_ucas_n}, 3'b111);
        req_valid = 1'b1; req_write = 1'b1; req_addr = {9'd5, 9'd11};
        req_be = 2'b11; req_wdata = 16'hDEAD;
        blocked = 1;
        for (int i = 0; i < 6; i++) begin
            if (req_ready) blocked = 0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        refresh_req = 1'b0;
        chk(blocked, "R10 no accept during refresh", blocked, 1);
        access(0, 9'd5, 9'd11, 2'b11, 16'h0, rd, busy);
        chk(rd == 16'hBEEF, "R10 blocked write had no effect", rd, 16'hBEEF);
    endtask

    task automatic t_protocol();
        chk(prot_err == 0, "R3 R5 strobe timing and early write", prot_err, 0);
        chk(wr_strobes > 0, "R5 writes observed", wr_strobes, 1);
    endtask

    // ---------------- sequence and watchdog ----------------
    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word();
        t_hit();
        t_byte();
        t_miss();
        t_stream();
        t_idle_close();
        t_refresh();
        t_protocol();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule